// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Alarm

This block keeps a 32-bit count of elapsed seconds and advances it from the system clock. A 32-bit rate word says how many clock cycles make up one second, so the counter steps by one each time that many cycles have passed. Software programs it over a simple 16-bit register bus, where each 32-bit value is split into a low half and a high half.

Setting the time and reading it back both go through handshake bits that clear themselves. One bit copies a staged 32-bit preset into the counter and restarts the second phase. The other freezes the running count into a pair of read-only registers, so that the two halves read afterwards belong to the same instant. A 32-bit compare value raises a pending alarm when the count reaches it. The interrupt output follows that alarm, and software can mask it, force it or acknowledge it. An active-low run bit acts as a soft reset for the time-keeping logic and leaves the programmed words alone.

Top module: `sec_rtc`

## Requirements
- R1: The word offsets are: control 0x00, rate word low 0x04 and high 0x08, preset low 0x0C and high 0x10, compare low 0x14 and high 0x18, status 0x1C, snapshot low 0x20 and high 0x24. A read returns the addressed register on `bus_rdata` one clock after the address is presented. After `rst`, control reads 0x0001, the rate word reads the `FREQ_RESET` default, status reads 0, the snapshot reads 0 and `irq` is 0.
- R2: Control bit 0 is run (active-low soft reset), bit 1 is count enable, bit 2 is wrap enable, bit 3 is load, bit 4 is snapshot, bit 5 is interrupt mask, bit 6 is interrupt force and bit 7 is acknowledge. Bits 15:8 are ignored on write and read as 0.
- R3: Writing control with bit 3 set copies the preset into the counter on the next clock. Bit 3 then reads back as 0.
- R4: Writing control with bit 4 set copies the counter into the snapshot registers on the next clock. Bit 4 then reads back as 0, and the snapshot holds its value until the next request.
- R5: With a rate word F of 1 or more, the counter advances once every F clock cycles. A load restarts the second phase, so a full F cycles pass before the first step after the load.
- R6: While count enable is 0, the counter does not advance.
- R7: With wrap enable at 1, the count rolls from 0xFFFFFFFF to 0. With wrap enable at 0, it stays at 0xFFFFFFFF.
- R8: When the count becomes equal to the compare value, a pending alarm is set. Status bit 0 is raw (pending OR force) and status bit 1 is raw AND NOT mask. The `irq` output is a registered copy of status bit 1.
- R9: While the mask bit is 1, `irq` is 0 on the following clock and status bit 1 reads 0. Status bit 0 still shows the pending alarm.
- R10: Force (control bit 6) drives the raw condition to 1 for as long as it is set.
- R11: Writing control with bit 7 set clears the pending alarm on the next clock. Bit 7 then reads back as 0.
- R12: While run is 0, the phase counter, the seconds counter and the pending alarm are cleared. The rate word, preset and compare registers keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, which is also the time reference |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte offset of the register being addressed |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data for the address of the previous cycle |
| irq | output | 1 | Alarm interrupt, level, registered |

## Verification
The hardest behaviour to reach from the ports is the restart of the second phase on a load. A step that is already partly counted is only visible if the load lands mid-second and the counter is then stopped before a full second has passed. The bench times the load so that the old phase would complete a step within the stop window, then checks that the snapshot still equals the preset. Rate checks use stop points half a second away from any step boundary, so an off-by-one cycle cannot hide a wrong tick rate. Wrap and hold are reached by presetting 0xFFFFFFFE instead of counting there.

// File: rtl/sec_rtc_pkg.sv
`timescale 1ns/1ps
package sec_rtc_pkg;
  localparam int ADDR_W = 6;
  localparam int CTRL_W = 8;

  localparam logic [ADDR_W-1:0] A_CTRL    = 6'h00;
  localparam logic [ADDR_W-1:0] A_RATE_LO = 6'h04;
  localparam logic [ADDR_W-1:0] A_RATE_HI = 6'h08;
  localparam logic [ADDR_W-1:0] A_PRE_LO  = 6'h0C;
  localparam logic [ADDR_W-1:0] A_PRE_HI  = 6'h10;
  localparam logic [ADDR_W-1:0] A_CMP_LO  = 6'h14;
  localparam logic [ADDR_W-1:0] A_CMP_HI  = 6'h18;
  localparam logic [ADDR_W-1:0] A_STAT    = 6'h1C;
  localparam logic [ADDR_W-1:0] A_SNAP_LO = 6'h20;
  localparam logic [ADDR_W-1:0] A_SNAP_HI = 6'h24;

  // control bit positions
  localparam int B_RUN   = 0;
  localparam int B_EN    = 1;
  localparam int B_WRAP  = 2;
  localparam int B_LOAD  = 3;
  localparam int B_SNAP  = 4;
  localparam int B_MASK  = 5;
  localparam int B_FORCE = 6;
  localparam int B_ACK   = 7;

  localparam logic [CTRL_W-1:0] CTRL_RESET = 8'h01;
endpackage

// File: rtl/sec_rtc_prescale.sv
`timescale 1ns/1ps
module sec_rtc_prescale #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic [CNT_W-1:0] rate,
  output logic             tick
);
  logic [CNT_W-1:0] phase_q;
  logic [CNT_W-1:0] last_phase;
  logic             at_last;

  // a rate of zero behaves like one: a step on every cycle
  assign last_phase = (rate == '0) ? '0 : rate - 1'b1;
  assign at_last    = (phase_q >= last_phase);
  assign tick       = en & at_last & ~clr;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      phase_q <= '0;
    end else if (en) begin
      phase_q <= at_last ? '0 : phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/sec_rtc_seconds.sv
`timescale 1ns/1ps
module sec_rtc_seconds #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] preset,
  input  logic             tick,
  input  logic             wrap,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
    end else if (load) begin
      count <= preset;
    end else if (tick) begin
      if (count != TOP) begin
        count <= count + 1'b1;
      end else if (wrap) begin
        count <= '0;
      end
    end
  end
endmodule

// File: rtl/sec_rtc_alarm.sv
`timescale 1ns/1ps
module sec_rtc_alarm #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] compare,
  input  logic             ack,
  input  logic             force_on,
  input  logic             mask,
  output logic             pend,
  output logic             raw,
  output logic             alm,
  output logic             irq
);
  logic equal_now;
  logic equal_q;

  assign equal_now = (count == compare);
  assign raw       = (pend | force_on) & ~clr;
  assign alm       = raw & ~mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      equal_q <= 1'b1;
      pend    <= 1'b0;
      irq     <= 1'b0;
    end else begin
      equal_q <= equal_now;
      irq     <= alm;
      if (clr) begin
        pend <= 1'b0;
      end else if (equal_now && !equal_q) begin
        pend <= 1'b1;
      end else if (ack) begin
        pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sec_rtc.sv
`timescale 1ns/1ps
module sec_rtc
  import sec_rtc_pkg::*;
#(
  parameter int          BUS_W      = 16,
  parameter int unsigned FREQ_RESET = 32768
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq
);
  localparam int CNT_W = 2 * BUS_W;

  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  rate_q, preset_q, compare_q, snap_q, count;
  logic [BUS_W-1:0]  rd_mux;
  logic              run, cnt_en, wrap_en, ld_flag, mask_en;
  logic              tick, alarm_pend, alarm_raw, alarm_alm;

  assign run     = ctrl_q[B_RUN];
  assign cnt_en  = ctrl_q[B_EN];
  assign wrap_en = ctrl_q[B_WRAP];
  assign ld_flag = ctrl_q[B_LOAD];
  assign mask_en = ctrl_q[B_MASK];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= CTRL_RESET;
      rate_q    <= CNT_W'(FREQ_RESET);
      preset_q  <= '0;
      compare_q <= '0;
      snap_q    <= '0;
    end else begin
      // handshake bits live for one cycle
      ctrl_q[B_LOAD] <= 1'b0;
      ctrl_q[B_SNAP] <= 1'b0;
      ctrl_q[B_ACK]  <= 1'b0;
      if (ctrl_q[B_SNAP]) begin
        snap_q <= count;
      end
      if (bus_we) begin
        case (bus_addr)
          A_CTRL:    ctrl_q                   <= bus_wdata[CTRL_W-1:0];
          A_RATE_LO: rate_q[BUS_W-1:0]        <= bus_wdata;
          A_RATE_HI: rate_q[CNT_W-1:BUS_W]    <= bus_wdata;
          A_PRE_LO:  preset_q[BUS_W-1:0]      <= bus_wdata;
          A_PRE_HI:  preset_q[CNT_W-1:BUS_W]  <= bus_wdata;
          A_CMP_LO:  compare_q[BUS_W-1:0]     <= bus_wdata;
          A_CMP_HI:  compare_q[CNT_W-1:BUS_W] <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:    rd_mux = {{(BUS_W-CTRL_W){1'b0}}, ctrl_q};
      A_RATE_LO: rd_mux = rate_q[BUS_W-1:0];
      A_RATE_HI: rd_mux = rate_q[CNT_W-1:BUS_W];
      A_PRE_LO:  rd_mux = preset_q[BUS_W-1:0];
      A_PRE_HI:  rd_mux = preset_q[CNT_W-1:BUS_W];
      A_CMP_LO:  rd_mux = compare_q[BUS_W-1:0];
      A_CMP_HI:  rd_mux = compare_q[CNT_W-1:BUS_W];
      A_STAT:    rd_mux = {{(BUS_W-2){1'b0}}, alarm_alm, alarm_raw};
      A_SNAP_LO: rd_mux = snap_q[BUS_W-1:0];
      A_SNAP_HI: rd_mux = snap_q[CNT_W-1:BUS_W];
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  sec_rtc_prescale #(.CNT_W(CNT_W)) u_pre (
    .clk(clk), .rst(rst), .clr(~run | ld_flag), .en(cnt_en),
    .rate(rate_q), .tick(tick)
  );

  sec_rtc_seconds #(.CNT_W(CNT_W)) u_sec (
    .clk(clk), .rst(rst), .clr(~run), .load(ld_flag), .preset(preset_q),
    .tick(tick), .wrap(wrap_en), .count(count)
  );

  sec_rtc_alarm #(.CNT_W(CNT_W)) u_alm (
    .clk(clk), .rst(rst), .clr(~run), .count(count), .compare(compare_q),
    .ack(ctrl_q[B_ACK]), .force_on(ctrl_q[B_FORCE]), .mask(mask_en),
    .pend(alarm_pend), .raw(alarm_raw), .alm(alarm_alm), .irq(irq)
  );
endmodule

// File: rtl/sec_rtc_chk.sv
`timescale 1ns/1ps
module sec_rtc_chk
  import sec_rtc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              run,
  input logic              cnt_en,
  input logic              wrap_en,
  input logic              ld_flag,
  input logic              mask_en,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  preset,
  input logic              pend,
  input logic              irq,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              ld_wr_bit
);
  localparam logic [CNT_W-1:0] TOP = '1;

  // R3
  load_apply_chk: assert property (@(posedge clk) disable iff (rst)
    (run && ld_flag) |=> (count == $past(preset)));

  // R3
  load_selfclr_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_flag && !(bus_we && bus_addr == A_CTRL && ld_wr_bit)) |=> !ld_flag);

  // R6
  hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !cnt_en && !ld_flag) |=> (count == $past(count)));

  // R7
  saturate_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !wrap_en && !ld_flag && count == TOP) |=> (count == TOP));

  // R9
  masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    mask_en |=> !irq);

  // R12
  soft_reset_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (count == '0 && !pend));
endmodule

bind sec_rtc sec_rtc_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .run(run), .cnt_en(cnt_en), .wrap_en(wrap_en),
  .ld_flag(ld_flag), .mask_en(mask_en), .count(count), .preset(preset_q),
  .pend(alarm_pend), .irq(irq), .bus_we(bus_we), .bus_addr(bus_addr),
  .ld_wr_bit(bus_wdata[sec_rtc_pkg::B_LOAD])
);

// File: tb/sec_rtc_test.sv
`timescale 1ns/1ps
module sec_rtc_test;
  localparam logic [5:0] O_CTRL = 6'h00, O_RLO = 6'h04, O_RHI = 6'h08,
                         O_PLO = 6'h0C, O_PHI = 6'h10, O_CLO = 6'h14,
                         O_CHI = 6'h18, O_STAT = 6'h1C, O_SLO = 6'h20,
                         O_SHI = 6'h24;
  localparam logic [15:0] K_RUN = 16'h0001, K_EN = 16'h0002, K_WRAP = 16'h0004,
                          K_LOAD = 16'h0008, K_SNAP = 16'h0010, K_MASK = 16'h0020,
                          K_FORCE = 16'h0040, K_ACK = 16'h0080;

  // {rate[81:74], preset[73:42], span[41:34], wrap[33], enable[32], expected[31:0]}
  localparam int NV = 6;
  localparam logic [81:0] VEC [NV] = '{
    {8'd4, 32'd100,        8'd14, 1'b0, 1'b1, 32'd103},
    {8'd2, 32'h0001FFFE,   8'd7,  1'b0, 1'b1, 32'h00020001},
    {8'd4, 32'hFFFFFFFE,   8'd14, 1'b1, 1'b1, 32'h00000001},
    {8'd4, 32'hFFFFFFFE,   8'd14, 1'b0, 1'b1, 32'hFFFFFFFF},
    {8'd6, 32'd1000,       8'd21, 1'b0, 1'b1, 32'd1003},
    {8'd3, 32'h12345678,   8'd8,  1'b0, 1'b0, 32'h12345678}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;
  int          n_chk = 0;
  int          n_fail = 0;
  logic [15:0] rv;
  logic [31:0] cv, cv2;

  always #4 clk = ~clk;

  sec_rtc uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic snapshot(input logic [15:0] base, output logic [31:0] v);
    logic [15:0] lo, hi;
    wr(O_CTRL, base | K_SNAP);
    rd(O_SLO, lo);
    rd(O_SHI, hi);
    v = {hi, lo};
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(O_CTRL, rv);  check("R1 ctrl reset", {16'h0, rv}, 32'h0001);
    rd(O_STAT, rv);  check("R1 status reset", {16'h0, rv}, 32'h0);
    rd(O_SLO, rv);   check("R1 snapshot reset", {16'h0, rv}, 32'h0);
    rd(O_RLO, rv);   check("R1 rate reset", {16'h0, rv}, 32'h8000);
    check("R1 irq reset", {31'h0, irq}, 32'h0);

    // R2 control layout, upper byte ignored
    wr(O_CTRL, 16'hFF25);
    rd(O_CTRL, rv);  check("R2 ctrl readback", {16'h0, rv}, 32'h0025);
    wr(O_CTRL, K_RUN);

    // R5 R6 R7 vector table
    for (int i = 0; i < NV; i++) begin
      logic [81:0] v;
      logic [15:0] mode;
      v = VEC[i];
      mode = K_RUN | (v[33] ? K_WRAP : 16'h0);
      wr(O_CTRL, K_RUN);
      wr(O_RLO, {8'h0, v[81:74]});
      wr(O_RHI, 16'h0);
      wr(O_PLO, v[57:42]);
      wr(O_PHI, v[73:58]);
      wr(O_CTRL, mode | (v[32] ? K_EN : 16'h0) | K_LOAD);
      repeat (int'(v[41:34]) - 1) @(negedge clk);
      wr(O_CTRL, mode);
      snapshot(mode, cv);
      check($sformatf("R5 R6 R7 vector %0d", i), cv, v[31:0]);
    end

    // R3 load handshake: bit reads back clear, value applied
    wr(O_PLO, 16'h4321);
    wr(O_PHI, 16'h0765);
    wr(O_CTRL, K_RUN | K_LOAD);
    rd(O_CTRL, rv);  check("R3 load bit self-clears", {16'h0, rv}, 32'h0001);
    snapshot(K_RUN, cv); check("R3 preset applied", cv, 32'h07654321);

    // R4 snapshot stays stable while the counter runs
    wr(O_RLO, 16'd2);
    wr(O_CTRL, K_RUN | K_EN);
    snapshot(K_RUN | K_EN, cv);
    rd(O_CTRL, rv);  check("R4 snap bit self-clears", {16'h0, rv}, 32'h0003);
    repeat (10) @(negedge clk);
    rd(O_SLO, rv);   check("R4 snapshot held", {16'h0, rv}, {16'h0, cv[15:0]});
    snapshot(K_RUN | K_EN, cv2);
    check("R4 new snapshot advanced", {31'h0, (cv2 > cv)}, 32'h1);

    // R5 phase restart on load: rate 8, load mid-second
    wr(O_CTRL, K_RUN);
    wr(O_RLO, 16'd8);
    wr(O_PLO, 16'd500);
    wr(O_PHI, 16'd0);
    wr(O_CTRL, K_RUN | K_EN);
    repeat (2) @(negedge clk);
    wr(O_CTRL, K_RUN | K_EN | K_LOAD);
    repeat (4) @(negedge clk);
    wr(O_CTRL, K_RUN);
    snapshot(K_RUN, cv);
    check("R5 phase restarts on load", cv, 32'd500);

    // R8 alarm on match
    wr(O_CLO, 16'd50);
    wr(O_CHI, 16'd0);
    wr(O_RLO, 16'd2);
    wr(O_PLO, 16'd47);
    wr(O_CTRL, K_RUN | K_EN | K_LOAD);
    repeat (20) @(negedge clk);
    check("R8 irq after match", {31'h0, irq}, 32'h1);
    rd(O_STAT, rv);  check("R8 status after match", {16'h0, rv}, 32'h3);

    // R9 mask
    wr(O_CTRL, K_RUN | K_MASK);
    repeat (2) @(negedge clk);
    check("R9 irq masked", {31'h0, irq}, 32'h0);
    rd(O_STAT, rv);  check("R9 status masked", {16'h0, rv}, 32'h1);

    // R11 acknowledge
    wr(O_CTRL, K_RUN | K_MASK | K_ACK);
    rd(O_CTRL, rv);  check("R11 ack bit self-clears", {16'h0, rv}, 32'h0021);
    rd(O_STAT, rv);  check("R11 status cleared", {16'h0, rv}, 32'h0);
    wr(O_CTRL, K_RUN);
    repeat (2) @(negedge clk);
    check("R11 irq stays low after unmask", {31'h0, irq}, 32'h0);

    // R10 force
    wr(O_CTRL, K_RUN | K_FORCE);
    repeat (2) @(negedge clk);
    check("R10 irq forced", {31'h0, irq}, 32'h1);
    rd(O_STAT, rv);  check("R10 status forced", {16'h0, rv}, 32'h3);
    wr(O_CTRL, K_RUN);
    repeat (2) @(negedge clk);
    check("R10 force released", {31'h0, irq}, 32'h0);

    // R12 soft reset clears pending and count, keeps programmed words
    wr(O_PLO, 16'd49);
    wr(O_CTRL, K_RUN | K_EN | K_MASK | K_LOAD);
    repeat (10) @(negedge clk);
    rd(O_STAT, rv);  check("R12 pending before soft reset", {16'h0, rv}, 32'h1);
    wr(O_CTRL, K_MASK);
    repeat (2) @(negedge clk);
    wr(O_CTRL, K_RUN | K_MASK);
    rd(O_STAT, rv);  check("R12 pending cleared", {16'h0, rv}, 32'h0);
    snapshot(K_RUN | K_MASK, cv); check("R12 count cleared", cv, 32'h0);
    rd(O_CLO, rv);   check("R12 compare kept", {16'h0, rv}, 32'd50);
    rd(O_RLO, rv);   check("R12 rate kept", {16'h0, rv}, 32'd2);
    rd(O_PLO, rv);   check("R12 preset kept", {16'h0, rv}, 32'd49);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule